// File: doc/BRIEF.md
# Compressed VLIW Instruction Length Decoder

This block sits in the fetch path of a VLIW core whose instructions are packed at variable length. Every instruction has five issue slots. A 2-bit code per slot says whether the slot is unused or carries an operation of 26, 34 or 42 bits. The ten code bits that size an instruction do not travel inside that instruction. They are the low ten bits of a 16-bit word formed by the first two bytes of the instruction before it. The block consumes the code stream one byte per cycle. It keeps track of where each instruction ends and reports the length and slot layout of the instruction now arriving.

A start-of-tree strobe marks the entry of a new decision tree. No earlier instruction exists at that point, so the decoder loads a fixed seed word in which all five slots carry the widest code. The first instruction of a tree is therefore always 28 bytes. The outputs describe the current instruction from its first byte to its last. A one-cycle done pulse marks the boundary where the captured word takes over.

Top module: `vliw_len_decoder`

## Requirements
- R1: After reset the decoder holds the seed format 0x02AA: five slots of 42 bits each, a length of 224 bits (28 bytes), and instr_done low.
- R2: Slot i takes its code from format bits [2i+1:2i]. Codes 0, 1 and 2 give a slot size of 26, 34 and 42 on slot_size[6i+5:6i]. Code 3 gives size 0 and does not count in used_slots.
- R3: len_bits equals 16, plus 24, 32 or 40 for each used slot of code 0, 1 or 2, plus 8 when more than three slots are used. len_bytes equals len_bits divided by 8.
- R4: A format with all five slots at code 3 yields len_bits 16, len_bytes 2 and used_slots 0.
- R5: The first accepted byte of an instruction becomes fmt_word[7:0] and the second becomes fmt_word[15:8].
- R6: instr_done is high for exactly the one cycle after the last byte of an instruction is accepted. In that cycle, the length and slot outputs already describe fmt_word[9:0].
- R7: While tree_start is high, in_ready is low and no byte is taken. On the next cycle the format is the seed, the byte position is back at the first byte, and no done pulse is produced.
- R8: A byte is consumed only in a cycle with in_valid and in_ready both high. Idle cycles change neither the byte position nor any output.
- R9: fmt_word[15:10] has no effect on the length. A word of 0xFC00 sizes the next instruction as five 26-bit slots: 144 bits, 18 bytes.
- R10: The format bytes 7C then 47 give slot codes {0,3,3,1,3} for slots 0..4 and a next instruction of 72 bits (9 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tree_start | input | 1 | Start of a decision tree; reloads the seed format |
| in_valid | input | 1 | in_byte carries a code byte |
| in_byte | input | 8 | Next byte of the code stream |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| len_bits | output | 8 | Length of the current instruction in bits |
| len_bytes | output | 5 | Length of the current instruction in bytes |
| used_slots | output | 3 | Number of slots carrying an operation |
| slot_size | output | 30 | Per-slot operation size in bits, 6 bits per slot |
| fmt_word | output | 16 | Format word captured from the current instruction's first two bytes |
| instr_done | output | 1 | One-cycle pulse after the last byte of an instruction |

## Verification
The case hardest to reach from the ports is a 2-byte instruction. There the second byte is both the high half of the next format word and the last byte, so the captured word must feed the reload in the same cycle it arrives. The stimulus reaches it on purpose. It sends an instruction whose leading bytes encode an all-unused format, and then another whose leading bytes give a zero low field under set upper bits. A tree start is also dropped into the middle of an instruction, to show that the partial count and the pending word are discarded. A long random stream with idle gaps and occasional tree starts then runs against the behavioural model.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [1:0] {
        CODE_OP26 = 2'd0,
        CODE_OP34 = 2'd1,
        CODE_OP42 = 2'd2,
        CODE_NONE = 2'd3
    } slot_code_e;

    localparam int CODE_W   = 2;
    localparam int SIZE_W   = 6;
    localparam int HDR_BITS = 16;
    localparam int GRP_BITS = 8;
    localparam int FMT_FLAG = 2;

    function automatic logic [SIZE_W-1:0] code_to_size(input slot_code_e code);
        case (code)
            CODE_OP26: return SIZE_W'(26);
            CODE_OP34: return SIZE_W'(34);
            CODE_OP42: return SIZE_W'(42);
            default:   return SIZE_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/vld_slot_decode.sv
module vld_slot_decode
    import vld_pkg::*;
#(
    parameter int NSLOT = 5
) (
    input  logic [CODE_W*NSLOT-1:0] fmt,
    output logic [SIZE_W*NSLOT-1:0] slot_size,
    output logic [NSLOT-1:0]        slot_used
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_code_e code;
        assign code = slot_code_e'(fmt[CODE_W*s +: CODE_W]);
        assign slot_size[SIZE_W*s +: SIZE_W] = code_to_size(code);
        assign slot_used[s] = (code != CODE_NONE);
    end

endmodule

// File: rtl/vld_len_sum.sv
module vld_len_sum
    import vld_pkg::*;
#(
    parameter int NSLOT  = 5,
    parameter int SPLIT  = 3,
    parameter int LEN_W  = 8,
    parameter int BYTE_W = 5,
    parameter int CNT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SIZE_W*NSLOT-1:0] slot_size,
    input  logic [NSLOT-1:0]        slot_used,
    output logic [LEN_W-1:0]        len_bits,
    output logic [BYTE_W-1:0]       len_bytes,
    output logic [CNT_W-1:0]        used_cnt
);

    logic [LEN_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        acc = LEN_W'(HDR_BITS);
        cnt = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_used[s]) begin
                acc = acc + LEN_W'(slot_size[SIZE_W*s +: SIZE_W]) - LEN_W'(FMT_FLAG);
                cnt = cnt + CNT_W'(1);
            end
        end
        if (cnt > CNT_W'(SPLIT)) begin
            acc = acc + LEN_W'(GRP_BITS);
        end
    end

    assign len_bits  = acc;
    assign len_bytes = acc[LEN_W-1:3];
    assign used_cnt  = cnt;

    // R4: an instruction with no used slot is only its header
    p_empty_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (used_cnt == '0) |-> (len_bits == LEN_W'(HDR_BITS)));

    // R2: never more used slots than there are slots
    p_used_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= CNT_W'(NSLOT));

    // R3: length is a whole number of bytes
    p_byte_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_bits[2:0] == 3'd0);

endmodule

// File: rtl/vliw_len_decoder.sv
module vliw_len_decoder
    import vld_pkg::*;
#(
    parameter int          NSLOT = 5,
    parameter int          SPLIT = 3,
    parameter logic [15:0] SEED  = 16'h02AA,
    localparam int FW     = CODE_W * NSLOT,
    localparam int MAXLEN = HDR_BITS + NSLOT * 40 + GRP_BITS,
    localparam int LEN_W  = $clog2(MAXLEN + 1),
    localparam int BYTE_W = LEN_W - 3,
    localparam int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tree_start,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    output logic                    in_ready,
    output logic [LEN_W-1:0]        len_bits,
    output logic [BYTE_W-1:0]       len_bytes,
    output logic [CNT_W-1:0]        used_slots,
    output logic [SIZE_W*NSLOT-1:0] slot_size,
    output logic [15:0]             fmt_word,
    output logic                    instr_done
);

    typedef struct packed {
        logic [FW-1:0]     fmt;
        logic [15:0]       word;
        logic [BYTE_W-1:0] pos;
        logic              done;
    } state_t;

    state_t st_d, st_q;
    logic [NSLOT-1:0] slot_used;
    logic             take;
    logic [15:0]      word_nx;

    vld_slot_decode #(.NSLOT(NSLOT)) u_slots (
        .fmt       (st_q.fmt),
        .slot_size (slot_size),
        .slot_used (slot_used)
    );

    vld_len_sum #(
        .NSLOT (NSLOT),
        .SPLIT (SPLIT),
        .LEN_W (LEN_W),
        .BYTE_W(BYTE_W),
        .CNT_W (CNT_W)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_size (slot_size),
        .slot_used (slot_used),
        .len_bits  (len_bits),
        .len_bytes (len_bytes),
        .used_cnt  (used_slots)
    );

    assign in_ready = !tree_start;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        word_nx   = st_q.word;
        if (st_q.pos == BYTE_W'(0)) word_nx[7:0]  = in_byte;
        if (st_q.pos == BYTE_W'(1)) word_nx[15:8] = in_byte;
        if (tree_start) begin
            st_d.fmt = SEED[FW-1:0];
            st_d.pos = '0;
        end else if (take) begin
            st_d.word = word_nx;
            if (st_q.pos == len_bytes - BYTE_W'(1)) begin
                st_d.done = 1'b1;
                st_d.fmt  = word_nx[FW-1:0];
                st_d.pos  = '0;
            end else begin
                st_d.pos = st_q.pos + BYTE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fmt: SEED[FW-1:0], word: '0, pos: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt_word   = st_q.word;
    assign instr_done = st_q.done;

    // R7: a tree start blocks the byte input
    p_start_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tree_start |-> !in_ready);

    // R7: the seed is in force right after a tree start, with no done pulse
    p_seed_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tree_start |=> (st_q.fmt == SEED[FW-1:0]) && !instr_done && (st_q.pos == '0));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    // R8: without an accepted byte nothing advances
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !tree_start) |=> $stable(st_q.pos) && $stable(fmt_word) && !instr_done);

    // R3: the byte position stays inside the instruction
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos < len_bytes);

endmodule

// File: tb/vliw_len_decoder_bench.sv
module vliw_len_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tree_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic [7:0]  len_bits;
    logic [4:0]  len_bytes;
    logic [2:0]  used_slots;
    logic [29:0] slot_size;
    logic [15:0] fmt_word;
    logic        instr_done;

    int vectors = 0;
    int miscompares = 0;

    int m_fmt, m_word, m_pos, m_done;

    always #5 clk = ~clk;

    vliw_len_decoder u_vliw_len_decoder (
        .clk(clk), .rst_n(rst_n), .tree_start(tree_start), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .len_bits(len_bits),
        .len_bytes(len_bytes), .used_slots(used_slots), .slot_size(slot_size),
        .fmt_word(fmt_word), .instr_done(instr_done)
    );

    function automatic int m_code(input int f, input int s);
        return (f >> (2 * s)) & 3;
    endfunction

    function automatic int m_used(input int f);
        int u = 0;
        for (int s = 0; s < 5; s++) if (m_code(f, s) != 3) u++;
        return u;
    endfunction

    function automatic int m_len(input int f);
        int l = 16;
        for (int s = 0; s < 5; s++) if (m_code(f, s) != 3) l += 24 + 8 * m_code(f, s);
        if (m_used(f) > 3) l += 8;
        return l;
    endfunction

    function automatic int m_size(input int f, input int s);
        return (m_code(f, s) == 3) ? 0 : 26 + 8 * m_code(f, s);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R3", "len_bits", int'(len_bits), m_len(m_fmt));
        check("R3", "len_bytes", int'(len_bytes), m_len(m_fmt) / 8);
        check("R2", "used_slots", int'(used_slots), m_used(m_fmt));
        for (int s = 0; s < 5; s++)
            check("R2", "slot_size", int'(slot_size[6*s +: 6]), m_size(m_fmt, s));
        check("R6", "instr_done", int'(instr_done), m_done);
        check("R5", "fmt_word", int'(fmt_word), m_word);
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic ts);
        int w;
        in_valid = v; in_byte = b; tree_start = ts;
        #1;
        check("R7", "in_ready", int'(in_ready), ts ? 0 : 1);
        @(posedge clk);
        m_done = 0;
        if (ts) begin
            m_fmt = 'h2AA; m_pos = 0;
        end else if (v) begin
            w = m_word;
            if (m_pos == 0) w = (w & 'hFF00) | b;
            if (m_pos == 1) w = (w & 'h00FF) | (int'(b) << 8);
            m_word = w;
            if (m_pos == m_len(m_fmt) / 8 - 1) begin
                m_done = 1; m_fmt = w & 'h3FF; m_pos = 0;
            end else m_pos++;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic send(input logic [7:0] b, input bit gap);
        if (gap) step(1'b0, 8'hA5, 1'b0);   // R8: idle cycle, byte must not count
        step(1'b1, b, 1'b0);
    endtask

    // sends a whole instruction of n bytes whose first two bytes are lo, hi
    task automatic send_instr(input int n, input logic [7:0] lo, input logic [7:0] hi);
        send(lo, 1'b1);
        send(hi, 1'b0);
        for (int k = 2; k < n; k++) send(8'(k * 37), (k % 5) == 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        m_fmt = 'h2AA; m_word = 0; m_pos = 0; m_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: seed state after reset
        check("R1", "reset len_bits", int'(len_bits), 224);
        check("R1", "reset len_bytes", int'(len_bytes), 28);
        check("R1", "reset instr_done", int'(instr_done), 0);
        compare_all();

        // first instruction of the tree carries 7C 47 for the next one
        send_instr(28, 8'h7C, 8'h47);
        check("R10", "len_bits after 7C 47", int'(len_bits), 72);
        check("R10", "len_bytes after 7C 47", int'(len_bytes), 9);
        check("R2", "slot0 size", int'(slot_size[5:0]), 26);
        check("R2", "slot3 size", int'(slot_size[23:18]), 34);
        check("R2", "slot1 size", int'(slot_size[11:6]), 0);

        // 9-byte instruction leading with FF 03: next one has no used slot
        send_instr(9, 8'hFF, 8'h03);
        check("R4", "empty len_bits", int'(len_bits), 16);
        check("R4", "empty used_slots", int'(used_slots), 0);

        // 2-byte instruction leading with 00 FC: upper bits ignored
        send_instr(2, 8'h00, 8'hFC);
        check("R6", "done after 2-byte instr", int'(instr_done), 1);
        check("R9", "len_bits for 0xFC00", int'(len_bits), 144);
        check("R9", "len_bytes for 0xFC00", int'(len_bytes), 18);

        // R7: tree start part-way through the 18-byte instruction
        for (int k = 0; k < 7; k++) send(8'(k + 1), 1'b0);
        step(1'b1, 8'h11, 1'b1);
        check("R7", "seed len_bits after tree start", int'(len_bits), 224);
        check("R7", "no done after tree start", int'(instr_done), 0);
        send_instr(28, 8'h55, 8'h01);
        check("R3", "len_bits for 0x0155", int'(len_bits), m_len('h155));

        // random stream with gaps and rare tree starts
        for (int c = 0; c < 6000; c++) begin
            int r = $urandom_range(0, 999);
            step(r < 750, 8'($urandom), r > 995);
        end

        summary();
        $finish;
    end

endmodule